// File: doc/BRIEF.md
# Serial DAC Write Master

This block sits on the host side of a three-wire link to a serial digital-to-analog converter and sends it one 16-bit command frame per accepted request. A request carries a 12-bit output code and a 2-bit operating mode. It is taken on a valid/ready handshake. The block packs the word with two zero pad bits at the top and shifts it out most significant bit first. It drives an active-low frame sync, a serial clock that idles low and a data line. The receiver captures data on the falling clock edge, so the data line changes only on rising edges.

The serial clock runs at a programmable half period in system clock cycles. The block clamps that half period to a floor set at build time, which keeps the serial clock under the receiver's limit. An optional byte mode sends the frame as two 8-bit bursts with a pause between them, and sync stays low through the pause. After a frame, sync is parked high or low as a configuration input selects. Parking low saves receiver power. Before every frame, and before any other falling edge of sync, the block holds sync high for a guaranteed minimum number of cycles.

Top module: `dsw_master`

## Requirements
- R1: After reset, `dac_sync_n` is 1, `dac_sclk` is 0 and `cmd_ready` is 1.
- R2: Each accepted command yields exactly one frame of 16 bits sampled at the falling edges of `dac_sclk`, most significant bit first, equal to {2'b00, cmd_mode[1:0], cmd_code[11:0]}.
- R3: While `dac_sync_n` is low, `dac_sdo` changes only in the cycle in which `dac_sclk` rises, so it is unchanged across every falling edge.
- R4: `dac_sclk` is high only while `dac_sync_n` is low, and sync stays low from its fall until all 16 falling edges of the frame have occurred.
- R5: Each high phase and each in-frame low phase of `dac_sclk` lasts H system cycles, where H = max(cfg_half, MIN_HALF). The first rising edge comes exactly H cycles after `dac_sync_n` falls.
- R6: When `cfg_byte_mode` was 1 at acceptance, the low phase after the 8th falling edge lasts H + BYTE_GAP cycles and sync stays low across it.
- R7: With sync parked high, `dac_sync_n` rises exactly H cycles after the final falling edge, never in the same cycle.
- R8: Every falling edge of `dac_sync_n` is preceded by at least SYNC_HI_CYC consecutive cycles of sync high. With sync parked low, sync is raised for that time before the next frame starts.
- R9: When `cmd_ready` returns after a frame, `dac_sync_n` equals the inverse of the `cfg_park_low` value latched at acceptance.
- R10: `cmd_ready` is 0 in the cycle after a handshake and stays 0 until the frame and its sync spacing are finished, which takes at least 32·H cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_code | input | CODE_W (12) | Output code for the converter |
| cmd_mode | input | 2 | Operating mode bits placed below the pad bits |
| cfg_half | input | HALF_W (6) | Requested serial clock half period in system cycles |
| cfg_byte_mode | input | 1 | 1: send the frame as two 8-bit bursts |
| cfg_park_low | input | 1 | 1: leave sync low between frames |
| dac_sync_n | output | 1 | Active-low frame sync |
| dac_sclk | output | 1 | Serial clock, idle low |
| dac_sdo | output | 1 | Serial data, valid at falling clock edges |

## Verification
A wrong bit counter or a lost shift shows up at the ports as a word that mismatches at the end of the very frame it hits. A misloaded half-period or gap counter shows up as a clock phase of the wrong length at the next edge. A sync-timer fault shows up as a sync pulse that is too short just before the next frame. A state machine stuck in a spacing state leaves `cmd_ready` low and stalls the next command, and a sync release mid-frame is caught at that edge. Every phase length is measured against H, so each of these faults is visible within one frame.

// File: rtl/dsw_pkg.sv
package dsw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PRE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_BGAP,
        ST_GAP
    } dsw_state_e;

    localparam int PAD_BITS  = 2;
    localparam int MODE_BITS = 2;
endpackage

// File: rtl/dsw_frame_pack.sv
module dsw_frame_pack #(
    parameter int CODE_W = 12,
    localparam int WORD_W = dsw_pkg::PAD_BITS + dsw_pkg::MODE_BITS + CODE_W
) (
    input  logic [dsw_pkg::MODE_BITS-1:0] mode,
    input  logic [CODE_W-1:0]             code,
    output logic [WORD_W-1:0]             word
);
    assign word = {{dsw_pkg::PAD_BITS{1'b0}}, mode, code};
endmodule

// File: rtl/dsw_shifter.sv
module dsw_shifter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_word,
    input  logic         shift,
    output logic         msb
);
    logic [W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load)
            sh_d = load_word;
        else if (shift)
            sh_d = {sh_q[W-2:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign msb = sh_q[W-1];
endmodule

// File: rtl/dsw_hi_timer.sv
module dsw_hi_timer #(
    parameter int LIMIT = 5,
    localparam int TW = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_hi,
    output logic done
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!level_hi)
            cnt_d = '0;
        else if (cnt_q >= TW'(LIMIT))
            cnt_d = cnt_q;
        else
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // current cycle is at least the LIMIT-th consecutive high cycle
    assign done = level_hi && (cnt_q >= TW'(LIMIT - 1));
endmodule

// File: rtl/dsw_master.sv
module dsw_master
    import dsw_pkg::*;
#(
    parameter int HALF_W      = 6,
    parameter int MIN_HALF    = 3,
    parameter int SYNC_HI_CYC = 5,
    parameter int BYTE_GAP    = 6,
    parameter int CODE_W      = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [CODE_W-1:0] cmd_code,
    input  logic [1:0]        cmd_mode,
    input  logic [HALF_W-1:0] cfg_half,
    input  logic              cfg_byte_mode,
    input  logic              cfg_park_low,
    output logic              dac_sync_n,
    output logic              dac_sclk,
    output logic              dac_sdo
);
    localparam int FRAME_W = PAD_BITS + MODE_BITS + CODE_W;
    localparam int GW      = $clog2(BYTE_GAP + 1);
    localparam int CW      = (HALF_W > GW) ? HALF_W : GW;
    localparam int BW      = $clog2(FRAME_W + 1);

    typedef struct packed {
        dsw_state_e    st;
        logic          sync_n;
        logic          sclk;
        logic [CW-1:0] cnt;
        logic [CW-1:0] half;
        logic [BW-1:0] nbit;
        logic          byte_m;
        logic          park_lo;
    } regs_t;

    regs_t r_d, r_q;
    logic  load, shift, hi_done;
    logic [FRAME_W-1:0] word;
    logic [CW-1:0]      half_eff;

    dsw_frame_pack #(.CODE_W(CODE_W)) u_pack (
        .mode (cmd_mode),
        .code (cmd_code),
        .word (word)
    );

    dsw_shifter #(.W(FRAME_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_word (word),
        .shift     (shift),
        .msb       (dac_sdo)
    );

    dsw_hi_timer #(.LIMIT(SYNC_HI_CYC)) u_hi (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_hi (r_q.sync_n),
        .done     (hi_done)
    );

    assign half_eff = (cfg_half < HALF_W'(MIN_HALF)) ? CW'(MIN_HALF) : CW'(cfg_half);

    always_comb begin
        r_d   = r_q;
        load  = 1'b0;
        shift = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                // park low only once the sync-high minimum has elapsed
                r_d.sync_n = cfg_park_low ? (r_q.sync_n && !hi_done) : 1'b1;
                if (cmd_valid) begin
                    load        = 1'b1;
                    r_d.half    = half_eff;
                    r_d.byte_m  = cfg_byte_mode;
                    r_d.park_lo = cfg_park_low;
                    r_d.nbit    = '0;
                    r_d.sync_n  = 1'b1;
                    r_d.st      = ST_PRE;
                end
            end
            ST_PRE: begin
                r_d.sync_n = 1'b1;
                if (hi_done) begin
                    r_d.sync_n = 1'b0;
                    r_d.cnt    = r_q.half - 1'b1;
                    r_d.st     = ST_LEAD;
                end
            end
            ST_LEAD: begin
                if (r_q.cnt == '0) begin
                    r_d.sclk = 1'b1;
                    r_d.cnt  = r_q.half - 1'b1;
                    r_d.st   = ST_HIGH;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_HIGH: begin
                if (r_q.cnt == '0) begin
                    r_d.sclk = 1'b0;
                    r_d.cnt  = r_q.half - 1'b1;
                    r_d.nbit = r_q.nbit + 1'b1;
                    r_d.st   = ST_LOW;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_LOW: begin
                if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end else if (r_q.nbit == BW'(FRAME_W)) begin
                    if (r_q.park_lo) begin
                        r_d.st = ST_IDLE;
                    end else begin
                        r_d.sync_n = 1'b1;
                        r_d.st     = ST_GAP;
                    end
                end else if (r_q.byte_m && r_q.nbit == BW'(FRAME_W / 2)) begin
                    r_d.cnt = CW'(BYTE_GAP - 1);
                    r_d.st  = ST_BGAP;
                end else begin
                    shift    = 1'b1;
                    r_d.sclk = 1'b1;
                    r_d.cnt  = r_q.half - 1'b1;
                    r_d.st   = ST_HIGH;
                end
            end
            ST_BGAP: begin
                if (r_q.cnt == '0) begin
                    shift    = 1'b1;
                    r_d.sclk = 1'b1;
                    r_d.cnt  = r_q.half - 1'b1;
                    r_d.st   = ST_HIGH;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_GAP: begin
                r_d.sync_n = 1'b1;
                if (hi_done) r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q         <= '0;
            r_q.st      <= ST_IDLE;
            r_q.sync_n  <= 1'b1;
            r_q.half    <= CW'(MIN_HALF);
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd_ready  = (r_q.st == ST_IDLE);
    assign dac_sync_n = r_q.sync_n;
    assign dac_sclk   = r_q.sclk;
endmodule

// File: rtl/dsw_master_chk.sv
module dsw_master_chk #(
    parameter int MIN_HALF    = 3,
    parameter int SYNC_HI_CYC = 5
) (
    input logic clk,
    input logic rst_n,
    input logic cmd_valid,
    input logic cmd_ready,
    input logic dac_sync_n,
    input logic dac_sclk,
    input logic dac_sdo
);
    localparam int HW = $clog2(SYNC_HI_CYC + 1);
    localparam int LW = $clog2(MIN_HALF + 1);

    logic [HW-1:0] hi_q;
    logic [LW-1:0] lvl_q;
    logic [4:0]    fall_q;
    logic          sclk_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q        <= '0;
            lvl_q       <= '0;
            fall_q      <= '0;
            sclk_prev_q <= 1'b0;
        end else begin
            sclk_prev_q <= dac_sclk;
            if (!dac_sync_n)                    hi_q <= '0;
            else if (hi_q < HW'(SYNC_HI_CYC))   hi_q <= hi_q + 1'b1;
            if (dac_sclk != sclk_prev_q)        lvl_q <= LW'(1);
            else if (lvl_q < LW'(MIN_HALF))     lvl_q <= lvl_q + 1'b1;
            if (dac_sync_n)                     fall_q <= '0;
            else if (sclk_prev_q && !dac_sclk)  fall_q <= fall_q + 1'b1;
        end
    end

    // R3
    sdo_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(dac_sdo) && !dac_sync_n) |-> $rose(dac_sclk));
    // R4
    clk_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dac_sclk |-> !dac_sync_n);
    // R4
    frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_sync_n) |-> (fall_q == 5'd0 || fall_q == 5'd16));
    // R5
    half_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_sclk != sclk_prev_q) |-> (lvl_q >= LW'(MIN_HALF)));
    // R7
    release_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_sync_n) |-> !$past(dac_sclk));
    // R8
    sync_hi_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_sync_n) |-> (hi_q >= HW'(SYNC_HI_CYC)));
    // R10
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);
endmodule

bind dsw_master dsw_master_chk #(
    .MIN_HALF    (MIN_HALF),
    .SYNC_HI_CYC (SYNC_HI_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .dac_sync_n (dac_sync_n),
    .dac_sclk   (dac_sclk),
    .dac_sdo    (dac_sdo)
);

// File: tb/dsw_master_bench.sv
module dsw_master_bench;
    localparam int HALF_W      = 6;
    localparam int MIN_HALF    = 3;
    localparam int SYNC_HI_CYC = 5;
    localparam int BYTE_GAP    = 6;
    localparam int CODE_W      = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic              cmd_ready;
    logic [CODE_W-1:0] cmd_code = '0;
    logic [1:0]        cmd_mode = '0;
    logic [HALF_W-1:0] cfg_half = 6'd4;
    logic              cfg_byte_mode = 1'b0;
    logic              cfg_park_low = 1'b0;
    logic              dac_sync_n, dac_sclk, dac_sdo;

    always #4 clk = ~clk;

    dsw_master #(
        .HALF_W(HALF_W), .MIN_HALF(MIN_HALF), .SYNC_HI_CYC(SYNC_HI_CYC),
        .BYTE_GAP(BYTE_GAP), .CODE_W(CODE_W)
    ) u_dsw_master (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_code(cmd_code), .cmd_mode(cmd_mode), .cfg_half(cfg_half),
        .cfg_byte_mode(cfg_byte_mode), .cfg_park_low(cfg_park_low),
        .dac_sync_n(dac_sync_n), .dac_sclk(dac_sclk), .dac_sdo(dac_sdo)
    );

    typedef struct {
        logic [15:0] word;
        int          half;
        bit          bytem;
        bit          parklo;
    } item_t;

    item_t exp_q[$];
    int total = 0;
    int bad = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // monitor state
    bit    prev_sclk = 1'b0, prev_sync = 1'b1, prev_sdo = 1'b0;
    int    run = 0, since = 0, hi_run = 100, nbits = 0;
    bit    in_frame = 1'b0, done_pending = 1'b0;
    logic [15:0] got = '0;
    item_t cur = '{word: 16'h0, half: MIN_HALF, bytem: 1'b0, parklo: 1'b0};

    always @(negedge clk) begin
        if (rst_n) begin
            run++;
            since++;
            if (dac_sync_n) hi_run++;
            if (prev_sync && !dac_sync_n) begin
                check(hi_run >= SYNC_HI_CYC, "R8", "sync high time before fall", hi_run, SYNC_HI_CYC);
                since  = 0;
                hi_run = 0;
            end
            if (!prev_sync && dac_sync_n) begin
                if (in_frame) check(1'b0, "R4", "sync released mid-frame", nbits, 16);
                in_frame = 1'b0;
                if (done_pending)
                    check(run == cur.half, "R7", "sync release after last fall", run, cur.half);
                done_pending = 1'b0;
            end
            if (!prev_sclk && dac_sclk) begin
                if (dac_sync_n) check(1'b0, "R4", "clock rose with sync high", 1, 0);
                if (!in_frame) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R2", "frame without command", 1, 0);
                    end else begin
                        cur      = exp_q[0];
                        in_frame = 1'b1;
                        nbits    = 0;
                        got      = '0;
                        check(since == cur.half, "R5", "lead time sync to first rise", since, cur.half);
                    end
                end else if (cur.bytem && nbits == 8) begin
                    check(run == cur.half + BYTE_GAP, "R6", "low time between bytes", run, cur.half + BYTE_GAP);
                end else begin
                    check(run == cur.half, "R5", "clock low time", run, cur.half);
                end
                run = 0;
            end
            if (prev_sclk && !dac_sclk) begin
                if (in_frame) begin
                    check(run == cur.half, "R5", "clock high time", run, cur.half);
                    check(dac_sdo == prev_sdo, "R3", "data moved at falling edge", dac_sdo, prev_sdo);
                    got = {got[14:0], dac_sdo};
                    nbits++;
                    if (nbits == 16) begin
                        check(got == cur.word, "R2", "frame word", got, cur.word);
                        void'(exp_q.pop_front());
                        in_frame     = 1'b0;
                        done_pending = !cur.parklo;
                    end
                end
                run = 0;
            end
            prev_sclk = dac_sclk;
            prev_sync = dac_sync_n;
            prev_sdo  = dac_sdo;
        end
    end

    task automatic send(input logic [11:0] code, input logic [1:0] mode,
                        input int half, input bit bytem, input bit parklo);
        item_t it;
        int h;
        int waited;
        h = (half < MIN_HALF) ? MIN_HALF : half;
        it.word = {2'b00, mode, code};
        it.half = h;
        it.bytem = bytem;
        it.parklo = parklo;
        @(negedge clk);
        cfg_half      = HALF_W'(half);
        cfg_byte_mode = bytem;
        cfg_park_low  = parklo;
        cmd_code      = code;
        cmd_mode      = mode;
        cmd_valid     = 1'b1;
        exp_q.push_back(it);
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        check(cmd_ready == 1'b0, "R10", "ready after handshake", cmd_ready, 0);
        waited = 0;
        while (!cmd_ready) begin
            @(negedge clk);
            waited++;
        end
        check(waited >= 32 * h, "R10", "ready low for whole frame", waited, 32 * h);
        check(dac_sync_n == !parklo, "R9", "sync park level", dac_sync_n, !parklo);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(dac_sync_n == 1'b1, "R1", "sync after reset", dac_sync_n, 1);
        check(dac_sclk == 1'b0, "R1", "clock after reset", dac_sclk, 0);
        check(cmd_ready == 1'b1, "R1", "ready after reset", cmd_ready, 1);
        send(12'hA5C, 2'b01, 4, 1'b0, 1'b0);   // R2 R5 R7
        send(12'hFFF, 2'b11, 1, 1'b0, 1'b0);   // R5 clamp to MIN_HALF
        send(12'h123, 2'b10, 3, 1'b1, 1'b0);   // R6 byte bursts
        send(12'h000, 2'b00, 5, 1'b0, 1'b1);   // R9 park low
        send(12'h800, 2'b01, 3, 1'b1, 1'b1);   // R8 pulse before frame from parked low
        send(12'h7FF, 2'b10, 6, 1'b0, 1'b0);   // back to park high
        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R2", "frames left unsent", exp_q.size(), 0);
        finish_run();
    end

    initial begin
        repeat (50000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R10 watchdog expired: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end
endmodule